// File: doc/BRIEF.md
# Banked Direct Digital Synthesis Sine Generator

This core turns a digital tuning word into a stream of sine samples. A 32-bit phase accumulator advances by the active tuning word on every clock and wraps around. The top bits of the accumulator, plus a selected phase offset, form a 12-bit phase. A quarter-wave table, mirrored and negated by quadrant, converts that phase into a 10-bit offset-binary sample for a downstream converter. The output frequency is the clock rate times the tuning word over 2^32. Words at or above half scale are accepted but fold back below half the clock rate.

Two tuning words and four phase offsets are held in a register bank that is loaded through a strobed address/data write port. Select inputs pick the live entries on every clock. Retuning never clears or jumps the accumulator, so frequency hops are phase-continuous. A sleep input freezes the accumulator and the sample pipeline and parks the output at midscale. When sleep is released, generation resumes from the held phase.

Top module: `dds_synth_core`

## Requirements
- R1: While sleep is low, the accumulator adds the active tuning word on every clock and wraps modulo 2^32.
- R2: `freq_sel` picks tuning register 0 or 1 on every clock. Changing the select, or rewriting a tuning register, never resets or jumps the accumulator.
- R3: `phase_sel` picks one of four 12-bit offset registers. The offset is added modulo 4096 to accumulator bits 31:20, giving the 12-bit phase p.
- R4: A write with `wr_en` high stores data at the next clock edge. `wr_addr` 0 and 1 load tuning registers 0 and 1 with all 32 data bits. `wr_addr` 4 to 7 load offset registers 0 to 3 with data bits 11:0. Writes to `wr_addr` 2 and 3 change nothing.
- R5: For phase p, let q = p[11:10] and i = p[9:0]. The index is 1023-i when q[0] is 1, otherwise i. Let a = round(511·sin(π·(2·index+1)/4096)). The sample is 512+a when q[1] is 0, and 511-a when q[1] is 1.
- R6: A sample reaches `sample_out` 3 clocks after the accumulator value and offset selection that produced it. A newly written offset therefore appears at the output on the 4th edge after the write strobe.
- R7: While sleep is high at a clock edge, the accumulator and the pipeline hold and `sample_out` becomes 512. After sleep is released, generation continues from the held phase.
- R8: A synchronous reset clears the accumulator and all bank registers, and sets `sample_out` to 512.
- R9: Tuning words at or above 2^31 are accepted and processed exactly like any other word (aliased output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_addr | input | 3 | Register address (bit 2 picks the offset bank) |
| wr_data | input | 32 | Write data |
| freq_sel | input | 1 | Active tuning register |
| phase_sel | input | 2 | Active offset register |
| sleep | input | 1 | Freeze the core and park the output at midscale |
| sample_out | output | 10 | Offset-binary sine sample |

## Verification
The bench builds the core with its default parameters: a 32-bit accumulator, a 12-bit truncated phase, a 1024-entry quarter table, a 10-bit output, two tuning registers and four offset registers. At these sizes, a tuning word of 2^24 sweeps the whole table in 256 cycles, so every quadrant boundary and both mirror directions are reached. Words of 2^31 and above reach the Nyquist and aliasing cases, and wraparound of the 32-bit accumulator happens within a few cycles. A bench-side model predicts every sample from the stated formula and latency.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic {
        BANK_FREQ  = 1'b0,
        BANK_PHASE = 1'b1
    } bank_sel_e;

    // Amplitude magnitude of one quarter-wave entry, sampled at entry centres
    function automatic int quarter_amp(input int idx, input int addr_w, input int amp_w);
        real full_turn;
        real ang;
        real peak;
        full_turn = 4.0 * $itor(1 << addr_w);
        peak      = $itor((1 << amp_w) - 1);
        ang       = 3.141592653589793 * $itor(2 * idx + 1) / full_turn;
        return $rtoi(peak * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/dds_regbank.sv
module dds_regbank #(
    parameter int ACC_W   = 32,
    parameter int PHS_W   = 12,
    parameter int N_FREQ  = 2,
    parameter int N_PHASE = 4,
    localparam int FSEL_W = $clog2(N_FREQ),
    localparam int PSEL_W = $clog2(N_PHASE),
    localparam int IDX_W  = (FSEL_W > PSEL_W) ? FSEL_W : PSEL_W,
    localparam int AW     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic [FSEL_W-1:0] freq_sel,
    input  logic [PSEL_W-1:0] phase_sel,
    output logic [ACC_W-1:0]  ftw_act,
    output logic [PHS_W-1:0]  poff_act
);
    import dds_pkg::*;

    typedef struct packed {
        logic [N_FREQ-1:0][ACC_W-1:0]  ftw;
        logic [N_PHASE-1:0][PHS_W-1:0] poff;
    } bank_t;

    bank_t     bank_d, bank_q;
    bank_sel_e target;
    int        slot;

    always_comb begin
        bank_d = bank_q;
        target = bank_sel_e'(wr_addr[AW-1]);
        slot   = int'(wr_addr[IDX_W-1:0]);
        if (wr_en) begin
            for (int i = 0; i < N_FREQ; i++) begin
                if (target == BANK_FREQ && slot == i) begin
                    bank_d.ftw[i] = wr_data;
                end
            end
            for (int j = 0; j < N_PHASE; j++) begin
                if (target == BANK_PHASE && slot == j) begin
                    bank_d.poff[j] = wr_data[PHS_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign ftw_act  = bank_q.ftw[freq_sel];
    assign poff_act = bank_q.poff[phase_sel];

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32,
    parameter int PHS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic [ACC_W-1:0] ftw,
    input  logic [PHS_W-1:0] poff,
    output logic [ACC_W-1:0] acc_o,
    output logic [PHS_W-1:0] phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PHS_W-1:0] phase;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sleep) begin
            st_d.acc   = st_q.acc + ftw;
            // Truncate to the top bits, then rotate by the offset
            st_d.phase = st_q.acc[ACC_W-1 -: PHS_W] + poff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign phase_o = st_q.phase;

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
    parameter int PHS_W = 12,
    parameter int OUT_W = 10,
    localparam int LUT_AW = PHS_W - 2,
    localparam int LUT_N  = 1 << LUT_AW,
    localparam int AMP_W  = OUT_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic [PHS_W-1:0] phase_i,
    output logic [OUT_W-1:0] sample_o
);
    localparam logic [OUT_W-1:0] MIDSCALE = OUT_W'(1) << (OUT_W - 1);

    logic [AMP_W-1:0] rom [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_rom
        localparam int ENTRY = dds_pkg::quarter_amp(g, LUT_AW, AMP_W);
        assign rom[g] = AMP_W'(ENTRY);
    end

    typedef struct packed {
        logic             neg;
        logic [AMP_W-1:0] amp;
        logic [OUT_W-1:0] out;
    } lut_t;

    lut_t             st_d, st_q;
    logic [LUT_AW-1:0] fine;
    logic [LUT_AW-1:0] idx;

    always_comb begin
        st_d = st_q;
        fine = phase_i[LUT_AW-1:0];
        idx  = phase_i[PHS_W-2] ? ~fine : fine;
        if (sleep) begin
            st_d.out = MIDSCALE;
        end else begin
            st_d.neg = phase_i[PHS_W-1];
            st_d.amp = rom[idx];
            st_d.out = st_q.neg ? {1'b0, ~st_q.amp} : {1'b1, st_q.amp};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.neg <= 1'b0;
            st_q.amp <= '0;
            st_q.out <= MIDSCALE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.out;

endmodule

// File: rtl/dds_synth_core.sv
module dds_synth_core #(
    parameter int ACC_W   = 32,
    parameter int PHS_W   = 12,
    parameter int OUT_W   = 10,
    parameter int N_FREQ  = 2,
    parameter int N_PHASE = 4,
    localparam int FSEL_W = $clog2(N_FREQ),
    localparam int PSEL_W = $clog2(N_PHASE),
    localparam int IDX_W  = (FSEL_W > PSEL_W) ? FSEL_W : PSEL_W,
    localparam int AW     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic [FSEL_W-1:0] freq_sel,
    input  logic [PSEL_W-1:0] phase_sel,
    input  logic              sleep,
    output logic [OUT_W-1:0]  sample_out
);
    logic [ACC_W-1:0] ftw_act;
    logic [PHS_W-1:0] poff_act;
    logic [ACC_W-1:0] acc_w;
    logic [PHS_W-1:0] phase_w;

    dds_regbank #(
        .ACC_W(ACC_W), .PHS_W(PHS_W), .N_FREQ(N_FREQ), .N_PHASE(N_PHASE)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .freq_sel(freq_sel), .phase_sel(phase_sel),
        .ftw_act(ftw_act), .poff_act(poff_act)
    );

    dds_phase_acc #(
        .ACC_W(ACC_W), .PHS_W(PHS_W)
    ) u_acc (
        .clk(clk), .rst(rst), .sleep(sleep), .ftw(ftw_act), .poff(poff_act),
        .acc_o(acc_w), .phase_o(phase_w)
    );

    dds_sine_lut #(
        .PHS_W(PHS_W), .OUT_W(OUT_W)
    ) u_lut (
        .clk(clk), .rst(rst), .sleep(sleep), .phase_i(phase_w), .sample_o(sample_out)
    );

endmodule

// File: rtl/dds_synth_core_chk.sv
module dds_synth_core_chk #(
    parameter int ACC_W  = 32,
    parameter int PHS_W  = 12,
    parameter int OUT_W  = 10,
    parameter int FSEL_W = 1,
    parameter int PSEL_W = 2,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [ACC_W-1:0]  wr_data,
    input logic [FSEL_W-1:0] freq_sel,
    input logic [PSEL_W-1:0] phase_sel,
    input logic              sleep,
    input logic [OUT_W-1:0]  sample_out,
    input logic [ACC_W-1:0]  ftw_act,
    input logic [PHS_W-1:0]  poff_act,
    input logic [ACC_W-1:0]  acc
);
    localparam logic [OUT_W-1:0] MID       = OUT_W'(1) << (OUT_W - 1);
    localparam logic [AW-1:0]    ADDR_F0   = '0;
    localparam logic [AW-1:0]    ADDR_P0   = AW'(1) << (AW - 1);

    a_r1_acc_step: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> acc == $past(acc) + $past(ftw_act));

    a_r7_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        sleep |=> acc == $past(acc));

    a_r7_sleep_mid: assert property (@(posedge clk) disable iff (rst)
        sleep |=> sample_out == MID);

    a_r4_freq_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_F0) |=> (freq_sel != '0) || (ftw_act == $past(wr_data)));

    a_r3_phase_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_P0) |=> (phase_sel != '0) || (poff_act == $past(wr_data[PHS_W-1:0])));

    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (sample_out == MID) && (acc == '0));

endmodule

bind dds_synth_core dds_synth_core_chk #(
    .ACC_W(ACC_W), .PHS_W(PHS_W), .OUT_W(OUT_W),
    .FSEL_W(FSEL_W), .PSEL_W(PSEL_W), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .sleep(sleep),
    .sample_out(sample_out), .ftw_act(ftw_act), .poff_act(poff_act), .acc(acc_w)
);

// File: tb/dds_synth_core_tb.sv
`timescale 1ns/1ps
module dds_synth_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        freq_sel = 1'b0;
    logic [1:0]  phase_sel = '0;
    logic        sleep = 1'b0;
    logic [9:0]  sample_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dds_synth_core u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .freq_sel(freq_sel), .phase_sel(phase_sel), .sleep(sleep), .sample_out(sample_out)
    );

    // Sample value from a 12-bit phase, per R5
    function automatic logic [9:0] ref_sample(input logic [11:0] p);
        int k;
        int a;
        k = p[10] ? (1023 - int'(p[9:0])) : int'(p[9:0]);
        a = $rtoi(511.0 * $sin(3.141592653589793 * (2.0 * k + 1.0) / 4096.0) + 0.5);
        return p[11] ? 10'(511 - a) : 10'(512 + a);
    endfunction

    // Reference model built from R1..R8
    logic [31:0] m_acc;
    logic [11:0] m_ph;
    logic [9:0]  m_smp;
    logic [9:0]  m_out;
    logic [31:0] m_ftw [2];
    logic [11:0] m_off [4];

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= '0; m_ph <= '0; m_smp <= 10'd512; m_out <= 10'd512;
            m_ftw[0] <= '0; m_ftw[1] <= '0;
            for (int i = 0; i < 4; i++) m_off[i] <= '0;
        end else begin
            if (wr_en) begin
                if (wr_addr == 3'd0) m_ftw[0] <= wr_data;
                if (wr_addr == 3'd1) m_ftw[1] <= wr_data;
                if (wr_addr[2]) m_off[wr_addr[1:0]] <= wr_data[11:0];
            end
            if (sleep) begin
                m_out <= 10'd512;
            end else begin
                m_acc <= m_acc + m_ftw[freq_sel];
                m_ph  <= m_acc[31:20] + m_off[phase_sel];
                m_smp <= ref_sample(m_ph);
                m_out <= m_smp;
            end
        end
    end

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: sample_out=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock and compare against the model at the falling edge
    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk(tag, sample_out, m_out);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] ftw;
        logic [11:0] poff;
        logic        fsel;
        logic [1:0]  psel;
        logic [15:0] cycles;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ftw: 32'h0100_0000, poff: 12'h000, fsel: 1'b0, psel: 2'd0, cycles: 16'd300},
        '{ftw: 32'h0123_4567, poff: 12'h400, fsel: 1'b1, psel: 2'd1, cycles: 16'd200},
        '{ftw: 32'h8000_0000, poff: 12'h155, fsel: 1'b0, psel: 2'd2, cycles: 16'd50},
        '{ftw: 32'hC000_0001, poff: 12'hFFF, fsel: 1'b1, psel: 2'd3, cycles: 16'd100},
        '{ftw: 32'h0000_0001, poff: 12'h800, fsel: 1'b0, psel: 2'd0, cycles: 16'd50},
        '{ftw: 32'h3FFF_FFFF, poff: 12'h3FF, fsel: 1'b1, psel: 2'd1, cycles: 16'd100}
    };

    initial begin
        @(negedge clk);
        run(3, "R8 reset");
        chk("R8 reset midscale", sample_out, 10'd512);
        rst = 1'b0;
        run(4, "R8 idle");

        // R6: offset written with a zero tuning word reaches the output on edge 4
        wr(3'd4, 32'h0000_0400, "R6 write");
        step("R6 edge2");
        chk("R6 not yet", sample_out, 10'd512);
        step("R6 edge3");
        chk("R6 not yet", sample_out, 10'd512);
        step("R6 edge4");
        chk("R6 arrives", sample_out, 10'd1023);
        run(3, "R6 steady");

        // Table walk: R1 R5 R6 with several words, R9 for words at or above 2^31
        for (int v = 0; v < 6; v++) begin
            string tag;
            tag = (v == 2 || v == 3) ? "R9 R1 R5" : "R1 R5 R6";
            wr({2'b00, VECS[v].fsel}, VECS[v].ftw, tag);
            wr({1'b1, VECS[v].psel}, {20'd0, VECS[v].poff}, "R3 R4");
            freq_sel = VECS[v].fsel;
            phase_sel = VECS[v].psel;
            run(int'(VECS[v].cycles), tag);
        end

        // R2: hop between two words and rewrite the live one, no phase jump
        wr(3'd0, 32'h0200_0000, "R2 load");
        wr(3'd1, 32'h0730_0000, "R2 load");
        phase_sel = 2'd0;
        for (int h = 0; h < 12; h++) begin
            freq_sel = h[0];
            run(7, "R2 hop");
        end
        wr({2'b00, freq_sel}, 32'h0011_0000, "R2 rewrite live");
        run(20, "R2 after rewrite");

        // R3: switch among offsets while running
        wr(3'd5, 32'h0000_0200, "R3 load");
        wr(3'd6, 32'h0000_0A00, "R3 load");
        wr(3'd7, 32'hFFFF_F123, "R3 load");
        for (int s = 0; s < 16; s++) begin
            phase_sel = s[1:0];
            run(3, "R3 select");
        end

        // R4: addresses 2 and 3 are ignored; both tuning registers observed afterwards
        wr(3'd2, 32'hDEAD_BEEF, "R4 ignored addr");
        wr(3'd3, 32'h1234_5678, "R4 ignored addr");
        freq_sel = 1'b0; run(20, "R4 ignored f0");
        freq_sel = 1'b1; run(20, "R4 ignored f1");

        // R7: sleep freezes and parks, then resumes from the held phase
        sleep = 1'b1;
        for (int z = 0; z < 10; z++) begin
            step("R7 sleep");
            chk("R7 midscale", sample_out, 10'd512);
        end
        sleep = 1'b0;
        run(40, "R7 resume");
        sleep = 1'b1; step("R7 short sleep"); sleep = 1'b0;
        run(20, "R7 resume");

        // R8: reset in the middle of a run
        rst = 1'b1;
        step("R8 mid reset");
        chk("R8 mid reset midscale", sample_out, 10'd512);
        rst = 1'b0;
        run(10, "R8 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule